// File: doc/BRIEF.md
# Chip-Select Wait-State Acknowledge Generator

This block ends each data beat of an external bus cycle. Once a chip-select is active and a beat begins, it either counts down a programmed number of wait states and then pulses an internal acknowledge, or it waits for the external acknowledge pin. Either way it marks the end of the beat with a one-cycle terminate pulse. When an internally acknowledged beat belongs to a burst, it also pulses an address-increment strobe. It is used next to the chip-select decoder and the data path of an external memory controller. The per-chip-select settings come in as static inputs: a 6-bit wait count, an auto-acknowledge enable and an external-acknowledge enable.

The controller is a three-state machine:
- `ST_IDLE` means no beat is pending.
- `ST_COUNT` is the wait-state countdown when auto-acknowledge is on.
- `ST_WAIT_EXT` waits for the external acknowledge when auto-acknowledge is off.

Its transitions:
- **start-count** (IDLE/COUNT/WAIT_EXT to COUNT): a beat start with auto-acknowledge on.
- **start-wait** (any state to WAIT_EXT): a beat start with auto-acknowledge off.
- **expire** (COUNT to IDLE): the count reaches zero.
- **ext-term** (COUNT or WAIT_EXT to IDLE): the enabled external acknowledge arrives.
- **cs-drop** (any state to IDLE): the chip-select is released.

A beat start while a beat is in progress reloads the full count.

Top module: `cs_ack_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it, `int_ack`, `beat_done` and `addr_inc` are 0 and the machine is idle.
- R2: With `auto_ack_en`=1 and no external termination, if `beat_start` is sampled high at clock edge E0 with wait count N (0..63), then `int_ack` and `beat_done` are high for the cycle that follows edge E0+N+1.
- R3: `int_ack` is a single-cycle pulse, produced once per internally ended beat, and `beat_done` is high whenever `int_ack` is.
- R4: With `auto_ack_en`=1 and `ext_ack_en`=1, an `ext_ack_in` sampled high at an edge before or at the edge where the count would expire ends the beat. `beat_done` is high in the following cycle, and no `int_ack` is produced for that beat. The external acknowledge wins a tie.
- R5: With `auto_ack_en`=0, `int_ack` never rises. The beat ends with `beat_done` in the cycle after the first edge at which `ext_ack_in` is sampled high with `ext_ack_en`=1.
- R6: `ext_ack_in` has no effect while `ext_ack_en`=0.
- R7: `addr_inc` pulses together with `int_ack` only when `burst` is 1 at the terminating edge. It never pulses on an externally ended beat.
- R8: A `beat_start` during a beat in progress restarts the full wait count from that edge.
- R9: `cs_active`=0 returns the machine to idle. The pending beat then produces neither `beat_done` nor `int_ack`.
- R10: `cfg_err` is 1 exactly when `auto_ack_en` and `ext_ack_en` are both 0, and 0 otherwise (combinational).
- R11: `beat_start` is ignored while `cs_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_cfg | input | 6 | Wait-state count for the selected chip-select |
| auto_ack_en | input | 1 | Internal acknowledge enable |
| ext_ack_en | input | 1 | External acknowledge pin enable |
| cs_active | input | 1 | Chip-select asserted |
| beat_start | input | 1 | Pulse marking the start of a data beat |
| burst | input | 1 | Current cycle is a burst |
| ext_ack_in | input | 1 | External acknowledge |
| int_ack | output | 1 | Internal acknowledge pulse |
| beat_done | output | 1 | Beat terminated pulse |
| addr_inc | output | 1 | Burst address advance pulse |
| cfg_err | output | 1 | Both acknowledge sources disabled |

## Verification
The assertions check the following on every cycle:
- the counter loads and steps correctly, and never decrements past zero;
- an acknowledge is always a lone pulse;
- an address increment always comes with an internal acknowledge;
- a released chip-select forces idle;
- an enabled external acknowledge during a countdown ends the beat without an internal acknowledge;
- the wait-external state never yields an internal acknowledge.

Only the bench scenarios can show that the exact termination cycle matches the programmed count at 0, mid-range and 63. They also show the tie between expiry and an external acknowledge, the restart on a second beat start, and the silence that follows a chip-select drop or a misconfiguration.

// File: rtl/cs_ack_pkg.sv
package cs_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_WAIT_EXT = 2'd2
    } ack_state_t;
endpackage

// File: rtl/ws_countdown.sv
module ws_countdown #(
    parameter int WS_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            dec,
    output logic            zero
);
    logic [WS_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clr)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec)
            remain <= remain - 1'b1;
    end

    assign zero = (remain == '0);

    // R2: a load captures the programmed count
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (remain == $past(load_val)));

    // R2: each decrement removes exactly one wait state
    p_dec_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr) |=> (remain == WS_W'($past(remain) - 1'b1)));

    // R2: the controller never decrements an exhausted count
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        dec |-> !zero);
endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
    import cs_ack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_active,
    input  logic beat_start,
    input  logic burst,
    input  logic ext_ack_in,
    input  logic auto_ack_en,
    input  logic ext_ack_en,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_dec,
    output logic cnt_clr,
    output logic int_ack,
    output logic beat_done,
    output logic addr_inc
);
    ack_state_t state, nxt_state;
    logic       ext_hit;
    logic       fire_int;
    logic       fire_ext;

    assign ext_hit  = ext_ack_en && ext_ack_in;
    assign cnt_clr  = !cs_active;
    assign cnt_load = cs_active && beat_start && auto_ack_en;

    always_comb begin
        nxt_state = state;
        fire_int  = 1'b0;
        fire_ext  = 1'b0;
        cnt_dec   = 1'b0;
        if (!cs_active) begin
            nxt_state = ST_IDLE;                       // cs-drop
        end else if (beat_start) begin
            nxt_state = auto_ack_en ? ST_COUNT : ST_WAIT_EXT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt_state = ST_IDLE;
                end
                ST_COUNT: begin
                    if (ext_hit) begin
                        fire_ext  = 1'b1;              // ext-term
                        nxt_state = ST_IDLE;
                    end else if (cnt_zero) begin
                        fire_int  = 1'b1;              // expire
                        nxt_state = ST_IDLE;
                    end else begin
                        cnt_dec   = 1'b1;
                    end
                end
                ST_WAIT_EXT: begin
                    if (ext_hit) begin
                        fire_ext  = 1'b1;              // ext-term
                        nxt_state = ST_IDLE;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            int_ack   <= 1'b0;
            beat_done <= 1'b0;
            addr_inc  <= 1'b0;
        end else begin
            int_ack   <= fire_int;
            beat_done <= fire_int || fire_ext;
            addr_inc  <= fire_int && burst;
        end
    end

    // R3: internal acknowledge never lasts two cycles
    p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !int_ack);

    // R3: an internal acknowledge always terminates the beat
    p_ack_ends_beat_r3: assert property (@(posedge clk) disable iff (rst)
        int_ack |-> beat_done);

    // R7: address advances only with an internal acknowledge
    p_inc_needs_ack_r7: assert property (@(posedge clk) disable iff (rst)
        addr_inc |-> int_ack);

    // R9: a released chip-select forces idle
    p_cs_drop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> (state == ST_IDLE));

    // R4: enabled external acknowledge cuts a countdown short
    p_ext_cuts_count_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && cs_active && !beat_start && ext_ack_en && ext_ack_in)
        |=> (beat_done && !int_ack));

    // R5: waiting on the pin never yields an internal acknowledge
    p_wait_no_int_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_EXT) |=> !int_ack);
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard (
    input  logic auto_ack_en,
    input  logic ext_ack_en,
    output logic cfg_err
);
    // R10: a beat with neither source enabled can never end
    assign cfg_err = !(auto_ack_en || ext_ack_en);
endmodule

// File: rtl/cs_ack_gen.sv
module cs_ack_gen #(
    parameter int WS_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [WS_W-1:0] ws_cfg,
    input  logic            auto_ack_en,
    input  logic            ext_ack_en,
    input  logic            cs_active,
    input  logic            beat_start,
    input  logic            burst,
    input  logic            ext_ack_in,
    output logic            int_ack,
    output logic            beat_done,
    output logic            addr_inc,
    output logic            cfg_err
);
    logic cnt_load, cnt_dec, cnt_clr, cnt_zero;

    ws_countdown #(.WS_W(WS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (ws_cfg),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    ack_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cs_active   (cs_active),
        .beat_start  (beat_start),
        .burst       (burst),
        .ext_ack_in  (ext_ack_in),
        .auto_ack_en (auto_ack_en),
        .ext_ack_en  (ext_ack_en),
        .cnt_zero    (cnt_zero),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec),
        .cnt_clr     (cnt_clr),
        .int_ack     (int_ack),
        .beat_done   (beat_done),
        .addr_inc    (addr_inc)
    );

    cfg_guard u_cfg (
        .auto_ack_en (auto_ack_en),
        .ext_ack_en  (ext_ack_en),
        .cfg_err     (cfg_err)
    );

    // R1: no pulse on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!int_ack && !beat_done && !addr_inc));
endmodule

// File: tb/sim_cs_ack_gen.sv
module sim_cs_ack_gen;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] ws_cfg;
    logic       auto_ack_en, ext_ack_en, cs_active, beat_start, burst, ext_ack_in;
    logic       int_ack, beat_done, addr_inc, cfg_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    cs_ack_gen u0 (
        .clk(clk), .rst(rst), .ws_cfg(ws_cfg), .auto_ack_en(auto_ack_en),
        .ext_ack_en(ext_ack_en), .cs_active(cs_active), .beat_start(beat_start),
        .burst(burst), .ext_ack_in(ext_ack_in), .int_ack(int_ack),
        .beat_done(beat_done), .addr_inc(addr_inc), .cfg_err(cfg_err)
    );

    // {ws[6], auto, ext_en, burst, ext_cycle[8] (0 = none), done_cycle[8] (0 = never), int, inc}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {6'd0,  1'b1, 1'b1, 1'b0, 8'd0,  8'd1,  1'b1, 1'b0},  // R2 zero waits
        {6'd5,  1'b1, 1'b1, 1'b1, 8'd0,  8'd6,  1'b1, 1'b1},  // R2 R7 burst beat
        {6'd63, 1'b1, 1'b1, 1'b1, 8'd0,  8'd64, 1'b1, 1'b1},  // R2 max count
        {6'd10, 1'b1, 1'b1, 1'b1, 8'd4,  8'd4,  1'b0, 1'b0},  // R4 R7 early external
        {6'd3,  1'b1, 1'b1, 1'b1, 8'd4,  8'd4,  1'b0, 1'b0},  // R4 tie, external wins
        {6'd3,  1'b1, 1'b1, 1'b0, 8'd5,  8'd4,  1'b1, 1'b0},  // R2 R7 expiry before pin
        {6'd7,  1'b0, 1'b1, 1'b1, 8'd3,  8'd3,  1'b0, 1'b0},  // R5 auto off
        {6'd7,  1'b1, 1'b0, 1'b1, 8'd2,  8'd8,  1'b1, 1'b1},  // R6 pin disabled
        {6'd2,  1'b0, 1'b0, 1'b0, 8'd5,  8'd0,  1'b0, 1'b0},  // R10 R6 no source
        {6'd20, 1'b0, 1'b1, 1'b0, 8'd30, 8'd30, 1'b0, 1'b0}   // R5 long wait
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cs_active = 1'b0; beat_start = 1'b0; ext_ack_in = 1'b0; burst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int got, gi, ga, nint, ninc, ndone;
        rst = 1'b1; ws_cfg = '0; auto_ack_en = 1'b1; ext_ack_en = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R1 int_ack in reset", int_ack, 0);
        check("R1 beat_done in reset", beat_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 addr_inc after reset", addr_inc, 0);
        check("R1 beat_done after reset", beat_done, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [26:0] e;
            e = VEC[v];
            ws_cfg = e[26:21]; auto_ack_en = e[20]; ext_ack_en = e[19]; burst = e[18];
            cs_active = 1'b1; beat_start = 1'b1;
            @(negedge clk);
            beat_start = 1'b0;
            got = 0; gi = 0; ga = 0; nint = 0; ninc = 0;
            for (int k = 1; k <= 70; k++) begin
                ext_ack_in = (int'(e[17:10]) == k);
                @(negedge clk);
                if (beat_done && got == 0) begin
                    got = k; gi = int'(int_ack); ga = int'(addr_inc);
                end
                nint += int'(int_ack);
                ninc += int'(addr_inc);
            end
            ext_ack_in = 1'b0;
            check($sformatf("R2 R4 R5 R6 vec%0d done cycle", v), got, int'(e[9:2]));
            check($sformatf("R3 R4 R5 vec%0d int at done", v), gi, int'(e[1]));
            check($sformatf("R7 vec%0d inc at done", v), ga, int'(e[0]));
            check($sformatf("R3 vec%0d int pulse count", v), nint, int'(e[1]));
            check($sformatf("R7 vec%0d inc pulse count", v), ninc, int'(e[0]));
            idle_inputs();
            repeat (2) @(negedge clk);
        end

        // R10: all four enable combinations
        for (int c = 0; c < 4; c++) begin
            auto_ack_en = c[0]; ext_ack_en = c[1];
            #1;
            check($sformatf("R10 cfg_err combo %0d", c), cfg_err, (c == 0) ? 1 : 0);
        end

        // R8: second beat start mid-count restarts the full count
        ws_cfg = 6'd5; auto_ack_en = 1'b1; ext_ack_en = 1'b1; burst = 1'b0;
        @(negedge clk);
        cs_active = 1'b1; beat_start = 1'b1;
        @(negedge clk);
        beat_start = 1'b0;
        got = 0; ndone = 0;
        for (int k = 1; k <= 20; k++) begin
            beat_start = (k == 3);
            @(negedge clk);
            if (beat_done && got == 0) got = k;
            ndone += int'(beat_done);
        end
        beat_start = 1'b0;
        check("R8 restart done cycle", got, 9);
        check("R8 single termination", ndone, 1);
        idle_inputs();
        repeat (2) @(negedge clk);

        // R9: chip-select drop abandons the beat
        ws_cfg = 6'd10; cs_active = 1'b1; beat_start = 1'b1;
        @(negedge clk);
        beat_start = 1'b0;
        ndone = 0; nint = 0;
        for (int k = 1; k <= 20; k++) begin
            if (k == 4) cs_active = 1'b0;
            @(negedge clk);
            ndone += int'(beat_done);
            nint += int'(int_ack);
        end
        check("R9 no beat_done after cs drop", ndone, 0);
        check("R9 no int_ack after cs drop", nint, 0);

        // R11: beat start with chip-select inactive
        idle_inputs();
        ws_cfg = 6'd0;
        beat_start = 1'b1;
        @(negedge clk);
        beat_start = 1'b0;
        ndone = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            ndone += int'(beat_done);
        end
        check("R11 no beat without chip-select", ndone, 0);

        // R1: reset mid-beat clears outputs
        ws_cfg = 6'd1; cs_active = 1'b1; beat_start = 1'b1;
        @(negedge clk);
        beat_start = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ndone = 0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            ndone += int'(beat_done);
        end
        check("R1 reset abandons beat", ndone, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule